// File: doc/BRIEF.md
# Centre-aligned PWM channel with latched trip

A single PWM channel around an up-down time-base counter. The counter climbs from 0 to the programmed period and falls back to 0. A compare value, double-buffered through a shadow, sets the raw waveform on the rising match and clears it on the falling match. A dead-band stage turns the raw waveform into a complementary pair in active-low complementary polarity. Output A is the inverted, rising-edge-delayed source. Output B is the falling-edge-delayed source. The channel also emits a sync pulse at counter zero when it is a master. As a slave it can load a phase value into its counter on a sync input. An event pulse fires at zero, and optionally at the period as well.

A latched trip overrides both outputs to high. The state machine has three states. In TRIP_LATCHED the outputs are forced; this is the reset state. In TRIP_ARMED the outputs are still forced and a release waits for counter zero. In TRIP_RUN the dead-banded outputs drive the pins. The transitions are these:
- FORCE goes from any state to TRIP_LATCHED when a trip-force pulse arrives.
- CLEAR goes from TRIP_LATCHED to TRIP_ARMED on a trip-clear pulse with no force in the same cycle.
- RELEASE goes from TRIP_ARMED to TRIP_RUN in the counter-zero cycle with no force.

The counter keeps running through a trip and is never touched by a clear. Because the release lands on a zero boundary, the first pulse after recovery is always complete.

Top module: `cpwm_trip_chan`

## Requirements
- R1: The counter runs 0,1,…,P,P−1,…,1,0 with no repeated extreme, so counter-zero cycles are exactly 2·P clocks apart. The direction is up at 0 and down at P.
- R2: The active compare is loaded from `cmp_i` in every counter-zero cycle. When `load_on_prd_i`=1 it is also loaded in the cycle where the counter equals the period. A change of `cmp_i` between load points has no effect on the waveform.
- R3: The raw waveform goes high one clock after the counter equals the active compare while counting up. It goes low one clock after the equal match while counting down. With compare C and rising delay RED, A first goes low C+RED clocks after the sync-out pulse.
- R4: A compare value greater than the period produces no edges. A stays 1 and B stays 0 for the whole period.
- R5: A low means active. A is low for 2·(P−C)−RED clocks per period and B is high for 2·(P−C)+FED clocks per period. A is never low while B is low.
- R6: During reset the trip is latched: A=1, B=1, `sync_o`=0, `irq_o`=0.
- R7: A trip-force pulse makes A=1 and B=1 from the next clock. Both stay high until a clear is followed by a release.
- R8: A clear pulse only arms a release. The outputs resume in the clock after the next counter-zero cycle. A clear given in a zero cycle waits for the following zero. The zero spacing is unchanged, and the first period after release has full-length pulses.
- R9: A force in the same cycle as a clear leaves the trip latched with no release armed. A force while a release is armed cancels that release.
- R10: A clear pulse while the outputs are running changes nothing at the outputs.
- R11: `irq_o` pulses one clock after each counter-zero cycle. When `irq_both_i`=1 it also pulses one clock after the counter equals the period.
- R12: With `master_i`=1, `sync_o` pulses one clock after each counter-zero cycle. With `master_i`=0 it never pulses. A `sync_i` pulse with `phase_en_i`=1 loads `phase_i` (below P) into the counter, counting up, in the next clock. With `phase_en_i`=0 the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CW | Period P of the up-down count |
| cmp_i | input | CW | Shadow compare value |
| load_on_prd_i | input | 1 | Also load the compare at the period |
| red_dly_i | input | DW | Rising-edge delay in clocks |
| fed_dly_i | input | DW | Falling-edge delay in clocks |
| trip_force_i | input | 1 | Software trip-force pulse |
| trip_clr_i | input | 1 | Software trip-clear pulse |
| irq_both_i | input | 1 | Event pulse at period as well as zero |
| master_i | input | 1 | Emit sync-out at counter zero |
| sync_i | input | 1 | Sync-in pulse |
| phase_en_i | input | 1 | Enable phase loading on sync-in |
| phase_i | input | CW | Phase value loaded on sync-in |
| pwm_a_o | output | 1 | Output A, active low |
| pwm_b_o | output | 1 | Output B, complementary |
| sync_o | output | 1 | Sync-out pulse |
| irq_o | output | 1 | Event interrupt pulse |

## Verification
The checker watches several properties on every clock. A force blanks both outputs on the next clock and never leaves the channel running. The channel leaves the trip only straight after a zero cycle. A is never low while B is low. Event and sync pulses only follow zero or period cycles, and the counter never passes a stable period. Pulse widths, the offset of the first edge, shadow-load timing, the extra wait after a clear that lands in a zero cycle, and the whole first pulse after release are shown only by the bench's scenarios, which count output levels over complete periods.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        TRIP_LATCHED = 2'd0,
        TRIP_ARMED   = 2'd1,
        TRIP_RUN     = 2'd2
    } trip_state_e;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    input  logic          sync_i,
    input  logic          phase_en_i,
    input  logic [CW-1:0] phase_i,
    output logic [CW-1:0] cnt_o,
    output logic          up_o,
    output logic          zero_o,
    output logic          prd_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          up_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (sync_i && phase_en_i) begin
            if (phase_i >= period_i) begin
                cnt_q <= period_i;
                up_q  <= 1'b0;
            end else begin
                cnt_q <= phase_i;
                up_q  <= 1'b1;
            end
        end else if (period_i == '0) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_q >= period_i) begin
                cnt_q <= cnt_q - ONE;
                up_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q + ONE;
                up_q  <= ((cnt_q + ONE) != period_i);
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_q <= ONE;
                up_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - ONE;
                up_q  <= (cnt_q == ONE);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign up_o   = up_q;
    assign zero_o = (cnt_q == '0);
    assign prd_o  = (cnt_q == period_i);

endmodule

// File: rtl/cpwm_action.sv
module cpwm_action #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          up_i,
    input  logic          zero_i,
    input  logic          prd_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          load_on_prd_i,
    output logic          src_o
);
    logic [CW-1:0] act_cmp_q;
    logic          src_q;
    logic          load_w;
    logic          match_w;

    assign load_w  = zero_i || (load_on_prd_i && prd_i);
    assign match_w = (cnt_i == act_cmp_q);

    // active compare: all ones after reset so nothing matches before the first load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cmp_q <= '1;
        end else if (load_w) begin
            act_cmp_q <= cmp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
        end else if (match_w) begin
            src_q <= up_i;
        end
    end

    assign src_o = src_q;

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_i,
    input  logic [DW-1:0] red_i,
    input  logic [DW-1:0] fed_i,
    output logic          rise_o,
    output logic          fall_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] hi_cnt_q;
    logic [DW-1:0] lo_cnt_q;

    // time spent high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !src_i) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != '1) begin
            hi_cnt_q <= hi_cnt_q + ONE;
        end
    end

    // time spent low, saturating; starts saturated so reset looks settled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt_q <= '1;
        end else if (src_i) begin
            lo_cnt_q <= '0;
        end else if (lo_cnt_q != '1) begin
            lo_cnt_q <= lo_cnt_q + ONE;
        end
    end

    assign rise_o = src_i && (hi_cnt_q >= red_i);
    assign fall_o = src_i || (lo_cnt_q < fed_i);

endmodule

// File: rtl/cpwm_trip_fsm.sv
module cpwm_trip_fsm
    import cpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    input  logic clr_i,
    input  logic zero_i,
    output logic run_o
);
    trip_state_e state_q;
    trip_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRIP_LATCHED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIP_LATCHED: begin
                if (!force_i && clr_i) begin
                    state_d = TRIP_ARMED;
                end
            end
            TRIP_ARMED: begin
                if (force_i) begin
                    state_d = TRIP_LATCHED;
                end else if (zero_i) begin
                    state_d = TRIP_RUN;
                end
            end
            TRIP_RUN: begin
                if (force_i) begin
                    state_d = TRIP_LATCHED;
                end
            end
            default: state_d = TRIP_LATCHED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TRIP_RUN: run_o = 1'b1;
            default:  run_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpwm_trip_chan.sv
module cpwm_trip_chan #(
    parameter int CW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          load_on_prd_i,
    input  logic [DW-1:0] red_dly_i,
    input  logic [DW-1:0] fed_dly_i,
    input  logic          trip_force_i,
    input  logic          trip_clr_i,
    input  logic          irq_both_i,
    input  logic          master_i,
    input  logic          sync_i,
    input  logic          phase_en_i,
    input  logic [CW-1:0] phase_i,
    output logic          pwm_a_o,
    output logic          pwm_b_o,
    output logic          sync_o,
    output logic          irq_o
);
    logic [CW-1:0] cnt_w;
    logic          up_w;
    logic          zero_w;
    logic          prd_w;
    logic          src_w;
    logic          rise_w;
    logic          fall_w;
    logic          run_w;
    logic          sync_q;
    logic          irq_q;

    cpwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .period_i(period_i),
        .sync_i(sync_i), .phase_en_i(phase_en_i), .phase_i(phase_i),
        .cnt_o(cnt_w), .up_o(up_w), .zero_o(zero_w), .prd_o(prd_w)
    );

    cpwm_action #(.CW(CW)) u_aq (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .up_i(up_w),
        .zero_i(zero_w), .prd_i(prd_w), .cmp_i(cmp_i),
        .load_on_prd_i(load_on_prd_i), .src_o(src_w)
    );

    cpwm_deadband #(.DW(DW)) u_db (
        .clk(clk), .rst_n(rst_n), .src_i(src_w),
        .red_i(red_dly_i), .fed_i(fed_dly_i),
        .rise_o(rise_w), .fall_o(fall_w)
    );

    cpwm_trip_fsm u_trip (
        .clk(clk), .rst_n(rst_n), .force_i(trip_force_i),
        .clr_i(trip_clr_i), .zero_i(zero_w), .run_o(run_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            sync_q <= master_i && zero_w;
            irq_q  <= zero_w || (irq_both_i && prd_w);
        end
    end

    // trip override sits after the dead-band pair
    assign pwm_a_o = run_w ? ~rise_w : 1'b1;
    assign pwm_b_o = run_w ?  fall_w : 1'b1;
    assign sync_o  = sync_q;
    assign irq_o   = irq_q;

endmodule

// File: rtl/cpwm_trip_chan_chk.sv
module cpwm_trip_chan_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trip_force_i,
    input logic          master_i,
    input logic [CW-1:0] period_i,
    input logic [CW-1:0] cnt_w,
    input logic          zero_w,
    input logic          run_w,
    input logic          pwm_a_o,
    input logic          pwm_b_o,
    input logic          sync_o,
    input logic          irq_o
);
    // R7
    force_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_force_i |=> (pwm_a_o && pwm_b_o));

    // R9
    force_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_force_i |=> !run_w);

    // R8
    release_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_w) |-> $past(zero_w));

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_a_o |-> pwm_b_o);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(zero_w || (cnt_w == period_i)));

    // R12
    sync_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> $past(master_i && zero_w));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(period_i) && ($past(cnt_w) <= $past(period_i))) |-> (cnt_w <= period_i));

endmodule

bind cpwm_trip_chan cpwm_trip_chan_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .trip_force_i(trip_force_i),
    .master_i(master_i), .period_i(period_i), .cnt_w(cnt_w),
    .zero_w(zero_w), .run_w(run_w), .pwm_a_o(pwm_a_o),
    .pwm_b_o(pwm_b_o), .sync_o(sync_o), .irq_o(irq_o)
);

// File: tb/cpwm_trip_chan_test.sv
`timescale 1ns/1ps
module cpwm_trip_chan_test;
    localparam int CW = 12;
    localparam int DW = 8;

    typedef struct packed {
        logic [15:0] prd;
        logic [15:0] cmp;
        logic [7:0]  red;
        logic [7:0]  fed;
        logic [15:0] alow;
        logic [15:0] bhigh;
        logic [15:0] aoff;
    } vec_t;

    localparam int NV = 5;
    // aoff 0xFFFF: no edge expected
    localparam vec_t VECS [NV] = '{
        '{16'd20,   16'd8,    8'd3,  8'd3,  16'd21,   16'd27,   16'd11},
        '{16'd30,   16'd25,   8'd2,  8'd4,  16'd8,    16'd14,   16'd27},
        '{16'd16,   16'd4,    8'd0,  8'd0,  16'd24,   16'd24,   16'd4},
        '{16'd20,   16'd26,   8'd3,  8'd3,  16'd0,    16'd0,    16'hFFFF},
        '{16'd2500, 16'd1250, 8'd75, 8'd75, 16'd2425, 16'd2575, 16'd1325}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] period_i = '0;
    logic [CW-1:0] cmp_i = '0;
    logic          load_on_prd_i = 1'b0;
    logic [DW-1:0] red_dly_i = '0;
    logic [DW-1:0] fed_dly_i = '0;
    logic          trip_force_i = 1'b0;
    logic          trip_clr_i = 1'b0;
    logic          irq_both_i = 1'b0;
    logic          master_i = 1'b1;
    logic          sync_i = 1'b0;
    logic          phase_en_i = 1'b0;
    logic [CW-1:0] phase_i = '0;
    logic          pwm_a_o, pwm_b_o, sync_o, irq_o;

    always #2.5 clk = ~clk;

    cpwm_trip_chan #(.CW(CW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .cmp_i(cmp_i),
        .load_on_prd_i(load_on_prd_i), .red_dly_i(red_dly_i), .fed_dly_i(fed_dly_i),
        .trip_force_i(trip_force_i), .trip_clr_i(trip_clr_i), .irq_both_i(irq_both_i),
        .master_i(master_i), .sync_i(sync_i), .phase_en_i(phase_en_i), .phase_i(phase_i),
        .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .sync_o(sync_o), .irq_o(irq_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int m_alow, m_bhigh, m_aoff, m_irq, m_irq_off, m_sync;
    int n;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        trip_force_i = 1'b0;
        trip_clr_i   = 1'b0;
        sync_i       = 1'b0;
    endtask

    task automatic wait_sync(output int steps);
        steps = 0;
        do begin
            step();
            steps++;
        end while (!sync_o && steps < 20000);
    endtask

    // samples 2P cycles starting with the current one
    task automatic measure(input int p);
        m_alow = 0; m_bhigh = 0; m_aoff = -1; m_irq = 0; m_irq_off = -1; m_sync = 0;
        for (int i = 0; i < 2 * p; i++) begin
            if (i > 0) step();
            if (!pwm_a_o) begin
                m_alow++;
                if (m_aoff < 0) m_aoff = i;
            end
            if (pwm_b_o) m_bhigh++;
            if (irq_o) begin
                m_irq++;
                m_irq_off = i;
            end
            if (sync_o) m_sync++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check("R6 reset A", int'(pwm_a_o), 1);
        check("R6 reset B", int'(pwm_b_o), 1);
        check("R6 reset sync", int'(sync_o), 0);
        check("R6 reset irq", int'(irq_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        // table walk
        for (int r = 0; r < NV; r++) begin
            period_i  = CW'(VECS[r].prd);
            cmp_i     = CW'(VECS[r].cmp);
            red_dly_i = VECS[r].red;
            fed_dly_i = VECS[r].fed;
            do_reset();
            wait_sync(n);
            if (r == 0) begin
                measure(20);
                check("R7 latched A low count", m_alow, 0);
                check("R7 latched B high count", m_bhigh, 40);
                wait_sync(n);
            end
            trip_clr_i = 1'b1;
            wait_sync(n);
            check("R1 R8 zero spacing across clear", n, 2 * int'(VECS[r].prd));
            measure(int'(VECS[r].prd));
            check("R5 R8 A low width", m_alow, int'(VECS[r].alow));
            check("R4 R5 B high width", m_bhigh, int'(VECS[r].bhigh));
            if (VECS[r].aoff != 16'hFFFF)
                check("R3 first A edge offset", m_aoff, int'(VECS[r].aoff));
        end

        // directed tests, P=20 C=8 RED=FED=3
        period_i = 12'd20; cmp_i = 12'd8; red_dly_i = 8'd3; fed_dly_i = 8'd3;
        do_reset();
        wait_sync(n);
        measure(20);
        trip_clr_i = 1'b1;            // clear lands in the zero cycle
        wait_sync(n);
        measure(20);
        check("R8 clear in zero cycle still tripped", m_bhigh, 40);
        wait_sync(n);
        measure(20);
        check("R8 released whole first pulse", m_alow, 21);
        check("R1 one sync per window", m_sync, 1);

        trip_clr_i = 1'b1;            // R10 clear while running
        wait_sync(n);
        measure(20);
        check("R10 clear ignored A width", m_alow, 21);
        check("R10 clear ignored B width", m_bhigh, 27);

        // R2 shadow loading
        wait_sync(n);
        cmp_i = 12'd12;
        measure(20);
        check("R2 old compare kept offset", m_aoff, 11);
        check("R2 old compare kept width", m_alow, 21);
        wait_sync(n);
        measure(20);
        check("R2 new compare offset", m_aoff, 15);
        check("R2 new compare width", m_alow, 13);
        wait_sync(n);
        load_on_prd_i = 1'b1;
        cmp_i = 12'd6;
        measure(20);
        check("R2 period load offset", m_aoff, 15);
        check("R2 period load A width", m_alow, 19);
        check("R2 period load B width", m_bhigh, 25);
        wait_sync(n);
        measure(20);
        check("R3 compare 6 offset", m_aoff, 9);
        check("R5 compare 6 width", m_alow, 25);
        wait_sync(n);
        load_on_prd_i = 1'b0;
        cmp_i = 12'd8;
        wait_sync(n);

        // R11 event pulses
        wait_sync(n);
        measure(20);
        check("R11 zero only count", m_irq, 1);
        check("R11 zero only offset", m_irq_off, 0);
        wait_sync(n);
        irq_both_i = 1'b1;
        measure(20);
        check("R11 both count", m_irq, 2);
        check("R11 period offset", m_irq_off, 20);
        irq_both_i = 1'b0;

        // R9 force and clear together
        wait_sync(n);
        trip_force_i = 1'b1;
        trip_clr_i   = 1'b1;
        step();
        check("R7 force A next cycle", int'(pwm_a_o), 1);
        check("R7 force B next cycle", int'(pwm_b_o), 1);
        wait_sync(n);
        measure(20);
        check("R9 force beats clear", m_bhigh, 40);

        // R9 force cancels an armed release
        wait_sync(n);
        trip_clr_i = 1'b1;
        step();
        trip_force_i = 1'b1;
        step();
        wait_sync(n);
        measure(20);
        check("R9 armed release cancelled", m_bhigh, 40);
        wait_sync(n);
        trip_clr_i = 1'b1;
        wait_sync(n);
        check("R8 release spacing", n, 40);

        // R12 sync-in and sync-out
        phase_en_i = 1'b1;
        phase_i = 12'd5;
        sync_i = 1'b1;
        wait_sync(n);
        check("R12 phase load spacing", n, 37);
        phase_en_i = 1'b0;
        sync_i = 1'b1;
        wait_sync(n);
        check("R12 sync ignored without phase enable", n, 40);
        master_i = 1'b0;
        step();
        measure(25);
        check("R12 slave emits no sync", m_sync, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule